// File: doc/BRIEF.md
# Sleep Entry and Exit Sequencer

This block governs the low-power sleep state of a synchronous static memory. A sleep request arrives with no timing relation to the clock. The block passes it through a flop synchronizer and then walks a fixed sequence. The sequence has an entry phase, a sleep phase, an exit phase and a post-exit recovery window. Each phase has a cycle count set by a parameter. Two outputs report the progress: one says the memory is asleep, and the other tells the access controller to take no new access.

The access controller normally receives the chip-enable and address-strobe inputs as they arrive. While the block is sequencing, those inputs are held at their inactive level on the forwarded outputs. Any of them seen active in that time counts as a protocol violation. An access that was in flight when sleep begins gets no further strobes, so it is treated as void. The block does not touch the memory contents, which are kept through sleep. The block does not reduce the supply current.

Top module: `sleep_seq`

## Requirements
- R1: After reset, `asleep_o`, `block_o` and `illegal_o` are 0, and each forwarded output equals its input.
- R2: When `sleep_req_i` rises and stays high, `block_o` rises at the third rising clock edge after the change. `asleep_o` rises at the fourth edge: two synchronizer edges plus an entry latency of two cycles.
- R3: When `sleep_req_i` falls while asleep, `asleep_o` stays 1 through the third rising edge after the change and falls at the fourth edge: two synchronizer edges plus an exit latency of two cycles.
- R4: After `asleep_o` falls, `block_o` stays 1 for a recovery window of two more rising edges and falls at the sixth edge after the request was released.
- R5: While `block_o` is 1, `ce_fwd_o`, `strobe_a_fwd_o` and `strobe_b_fwd_o` are 0 whatever the inputs are. While `block_o` is 0, each forwarded output equals its input in the same cycle.
- R6: If any bit of `ce_act_i`, `strobe_a_i` or `strobe_b_i` is 1 in a cycle where `block_o` is 1, `illegal_o` is 1 for the following cycle. Activity while `block_o` is 0 never raises `illegal_o`. This covers a memory that is still selected during entry.
- R7: A request held high for only one clock cycle still completes the full sequence. `asleep_o` is 1 after the fourth and fifth edges, and 0 after the sixth edge. `block_o` stays 1 until the eighth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Sleep request, asynchronous to clk, active high |
| ce_act_i | input | N_CE | Chip-enable inputs, a 1 means that enable is asserted |
| strobe_a_i | input | 1 | First address strobe, active high |
| strobe_b_i | input | 1 | Second address strobe, active high |
| ce_fwd_o | output | N_CE | Chip enables passed to the access controller |
| strobe_a_fwd_o | output | 1 | First strobe passed to the access controller |
| strobe_b_fwd_o | output | 1 | Second strobe passed to the access controller |
| asleep_o | output | 1 | Memory is in sleep, covering the sleep and exit phases |
| block_o | output | 1 | Access controller must not start accesses |
| illegal_o | output | 1 | Registered flag: activity was seen in a blocked cycle |

## Verification
The bench builds the block with its default parameters. These are a two-stage synchronizer, two-cycle entry and exit latencies, a two-cycle recovery window and three chip enables. With these values every phase boundary falls on a fixed edge count from the request change, so the bench checks each boundary exactly at that edge and one edge before it. The short recovery window lets the bench strike the gating and the violation flag inside recovery, during sleep, and again once awake. The one-cycle request pulse reaches the case where the release is already in the synchronizer before sleep begins.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [2:0] {
    ST_AWAKE = 3'd0,
    ST_ENTER = 3'd1,
    ST_SLEEP = 3'd2,
    ST_EXIT  = 3'd3,
    ST_RECOV = 3'd4
  } slp_state_t;

  // A latency phase of cyc cycles that ends in a state change: the
  // change edge itself is one of the cycles, the arming edge another.
  function automatic int unsigned latency_load(input int unsigned cyc);
    return (cyc >= 2) ? cyc - 2 : 0;
  endfunction

  // A dwell phase of cyc cycles counted from the arming edge.
  function automatic int unsigned dwell_load(input int unsigned cyc);
    return (cyc >= 1) ? cyc - 1 : 0;
  endfunction

  function automatic int unsigned max3(input int unsigned a, b, c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sleep_seq_sync.sv
module sleep_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sleep_seq_fsm.sv
module sleep_seq_fsm
  import sleep_seq_pkg::*;
#(
  parameter int unsigned ENTRY_CYC = 2,
  parameter int unsigned EXIT_CYC  = 2,
  parameter int unsigned RECOV_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  output slp_state_t state_o,
  output logic       ev_entry_start_o,
  output logic       ev_entry_done_o,
  output logic       ev_exit_start_o,
  output logic       ev_exit_done_o,
  output logic       ev_recov_done_o
);
  localparam int unsigned MAXC  = max3(ENTRY_CYC, EXIT_CYC, RECOV_CYC);
  localparam int unsigned CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] ENTRY_LD = CNT_W'(latency_load(ENTRY_CYC));
  localparam logic [CNT_W-1:0] EXIT_LD  = CNT_W'(latency_load(EXIT_CYC));
  localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(dwell_load(RECOV_CYC));

  slp_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  assign ev_entry_start_o = (state_q == ST_AWAKE) && req_i;
  assign ev_entry_done_o  = (state_q == ST_ENTER) && cnt_zero;
  assign ev_exit_start_o  = (state_q == ST_SLEEP) && !req_i;
  assign ev_exit_done_o   = (state_q == ST_EXIT)  && cnt_zero;
  assign ev_recov_done_o  = (state_q == ST_RECOV) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_AWAKE: if (req_i) begin
          state_q <= ST_ENTER;
          cnt_q   <= ENTRY_LD;
        end
        ST_ENTER: if (cnt_zero) state_q <= ST_SLEEP;
                  else          cnt_q   <= cnt_q - CNT_W'(1);
        ST_SLEEP: if (!req_i) begin
          state_q <= ST_EXIT;
          cnt_q   <= EXIT_LD;
        end
        ST_EXIT: if (cnt_zero) begin
          state_q <= ST_RECOV;
          cnt_q   <= RECOV_LD;
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_RECOV: if (cnt_zero) state_q <= ST_AWAKE;
                  else          cnt_q   <= cnt_q - CNT_W'(1);
        default:  state_q <= ST_AWAKE;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/sleep_seq_gate.sv
module sleep_seq_gate #(
  parameter int unsigned N_CE = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            block_i,
  input  logic [N_CE-1:0] ce_i,
  input  logic            sa_i,
  input  logic            sb_i,
  output logic [N_CE-1:0] ce_o,
  output logic            sa_o,
  output logic            sb_o,
  output logic            activity_o,
  output logic            illegal_o
);
  logic illegal_q;

  generate
    for (genvar i = 0; i < N_CE; i++) begin : g_ce
      assign ce_o[i] = ce_i[i] & ~block_i;
    end
  endgenerate

  assign sa_o       = sa_i & ~block_i;
  assign sb_o       = sb_i & ~block_i;
  assign activity_o = (|ce_i) | sa_i | sb_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= block_i & activity_o;
  end

  assign illegal_o = illegal_q;
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ENTRY_CYC   = 2,
  parameter int unsigned EXIT_CYC    = 2,
  parameter int unsigned RECOV_CYC   = 2,
  parameter int unsigned N_CE        = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_req_i,
  input  logic [N_CE-1:0] ce_act_i,
  input  logic            strobe_a_i,
  input  logic            strobe_b_i,
  output logic [N_CE-1:0] ce_fwd_o,
  output logic            strobe_a_fwd_o,
  output logic            strobe_b_fwd_o,
  output logic            asleep_o,
  output logic            block_o,
  output logic            illegal_o
);
  slp_state_t state;
  logic req_sync;
  logic ev_entry_start, ev_entry_done, ev_exit_start, ev_exit_done, ev_recov_done;
  logic activity;

  sleep_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(sleep_req_i), .sync_o(req_sync)
  );

  sleep_seq_fsm #(
    .ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_i(req_sync), .state_o(state),
    .ev_entry_start_o(ev_entry_start), .ev_entry_done_o(ev_entry_done),
    .ev_exit_start_o(ev_exit_start), .ev_exit_done_o(ev_exit_done),
    .ev_recov_done_o(ev_recov_done)
  );

  assign asleep_o = (state == ST_SLEEP) || (state == ST_EXIT);
  assign block_o  = (state != ST_AWAKE);

  sleep_seq_gate #(.N_CE(N_CE)) u_gate (
    .clk(clk), .rst_n(rst_n), .block_i(block_o),
    .ce_i(ce_act_i), .sa_i(strobe_a_i), .sb_i(strobe_b_i),
    .ce_o(ce_fwd_o), .sa_o(strobe_a_fwd_o), .sb_o(strobe_b_fwd_o),
    .activity_o(activity), .illegal_o(illegal_o)
  );
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk #(
  parameter int unsigned N_CE = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_sync,
  input logic            ev_entry_start,
  input logic            ev_entry_done,
  input logic            ev_exit_done,
  input logic            activity,
  input logic [N_CE-1:0] ce_fwd_o,
  input logic            strobe_a_fwd_o,
  input logic            strobe_b_fwd_o,
  input logic            asleep_o,
  input logic            block_o,
  input logic            illegal_o
);
  AST_BLOCK_GATES_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    block_o |-> !((|ce_fwd_o) || strobe_a_fwd_o || strobe_b_fwd_o)); // R5
  AST_ILLEGAL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $past(block_o && activity)); // R6
  AST_BLOCKED_ACTIVITY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (block_o && activity) |=> illegal_o); // R6
  AST_ENTRY_BLOCKS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_entry_start |=> (block_o && !asleep_o)); // R2
  AST_ENTRY_DONE_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_entry_done |=> asleep_o); // R2
  AST_SLEEP_UNDER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_o |-> block_o); // R4
  AST_EXIT_DONE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exit_done |=> (!asleep_o && block_o)); // R4
  AST_WAKE_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep_o) |-> $past(!req_sync, 2)); // R3
endmodule

bind sleep_seq sleep_seq_chk #(.N_CE(N_CE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_sync(req_sync),
  .ev_entry_start(ev_entry_start), .ev_entry_done(ev_entry_done),
  .ev_exit_done(ev_exit_done), .activity(activity),
  .ce_fwd_o(ce_fwd_o), .strobe_a_fwd_o(strobe_a_fwd_o),
  .strobe_b_fwd_o(strobe_b_fwd_o), .asleep_o(asleep_o),
  .block_o(block_o), .illegal_o(illegal_o)
);

// File: tb/sleep_seq_bench.sv
`timescale 1ns/1ps
module sleep_seq_bench;
  localparam int unsigned N_CE = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sleep_req_i = 1'b0;
  logic [N_CE-1:0] ce_act_i = '0;
  logic            strobe_a_i = 1'b0;
  logic            strobe_b_i = 1'b0;
  logic [N_CE-1:0] ce_fwd_o;
  logic            strobe_a_fwd_o, strobe_b_fwd_o, asleep_o, block_o, illegal_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sleep_seq u_sleep_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req_i), .ce_act_i(ce_act_i),
    .strobe_a_i(strobe_a_i), .strobe_b_i(strobe_b_i), .ce_fwd_o(ce_fwd_o),
    .strobe_a_fwd_o(strobe_a_fwd_o), .strobe_b_fwd_o(strobe_b_fwd_o),
    .asleep_o(asleep_o), .block_o(block_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic t_reset;
    ce_act_i = 3'b101; strobe_a_i = 1'b1;
    #1;
    chk("R1 asleep", 32'(asleep_o), 0);
    chk("R1 block", 32'(block_o), 0);
    chk("R1 illegal", 32'(illegal_o), 0);
    chk("R1 ce pass", 32'(ce_fwd_o), 32'h5);
    chk("R1 strobe_a pass", 32'(strobe_a_fwd_o), 1);
    ce_act_i = '0; strobe_a_i = 1'b0;
  endtask

  task automatic t_awake_traffic;
    strobe_b_i = 1'b1; ce_act_i = 3'b111;
    #1;
    chk("R5 strobe_b pass", 32'(strobe_b_fwd_o), 1);
    chk("R5 ce pass", 32'(ce_fwd_o), 32'h7);
    tick(1);
    chk("R6 awake no flag", 32'(illegal_o), 0);
    strobe_b_i = 1'b0; ce_act_i = '0;
    tick(1);
  endtask

  task automatic t_entry;
    sleep_req_i = 1'b1;
    tick(2);
    chk("R2 block before edge 3", 32'(block_o), 0);
    tick(1);
    chk("R2 block at edge 3", 32'(block_o), 1);
    chk("R2 asleep before edge 4", 32'(asleep_o), 0);
    ce_act_i = 3'b010;
    #1;
    chk("R5 ce gated in entry", 32'(ce_fwd_o), 0);
    tick(1);
    chk("R2 asleep at edge 4", 32'(asleep_o), 1);
    chk("R6 selected during entry", 32'(illegal_o), 1);
    ce_act_i = '0; strobe_a_i = 1'b1;
    #1;
    chk("R5 strobe_a gated in sleep", 32'(strobe_a_fwd_o), 0);
    tick(1);
    chk("R6 strobe in sleep", 32'(illegal_o), 1);
    strobe_a_i = 1'b0;
    tick(1);
    chk("R6 flag clears", 32'(illegal_o), 0);
    chk("R2 still asleep", 32'(asleep_o), 1);
  endtask

  task automatic t_exit;
    sleep_req_i = 1'b0;
    tick(3);
    chk("R3 asleep at edge 3", 32'(asleep_o), 1);
    tick(1);
    chk("R3 awake at edge 4", 32'(asleep_o), 0);
    chk("R4 recovery blocks", 32'(block_o), 1);
    strobe_b_i = 1'b1;
    #1;
    chk("R5 strobe_b gated in recovery", 32'(strobe_b_fwd_o), 0);
    tick(1);
    chk("R6 strobe in recovery", 32'(illegal_o), 1);
    chk("R4 block at edge 5", 32'(block_o), 1);
    strobe_b_i = 1'b0;
    tick(1);
    chk("R4 block released at edge 6", 32'(block_o), 0);
    strobe_b_i = 1'b1;
    #1;
    chk("R5 strobe_b passes after recovery", 32'(strobe_b_fwd_o), 1);
    tick(1);
    chk("R6 no flag after recovery", 32'(illegal_o), 0);
    strobe_b_i = 1'b0;
    tick(2);
  endtask

  task automatic t_pulse;
    sleep_req_i = 1'b1;
    tick(1);
    sleep_req_i = 1'b0;
    tick(2);
    chk("R7 block at edge 3", 32'(block_o), 1);
    chk("R7 asleep before edge 4", 32'(asleep_o), 0);
    tick(1);
    chk("R7 asleep at edge 4", 32'(asleep_o), 1);
    tick(1);
    chk("R7 asleep at edge 5", 32'(asleep_o), 1);
    tick(1);
    chk("R7 awake at edge 6", 32'(asleep_o), 0);
    tick(1);
    chk("R7 block at edge 7", 32'(block_o), 1);
    tick(1);
    chk("R7 block free at edge 8", 32'(block_o), 0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset;
    rst_n = 1'b1;
    tick(1);
    t_reset;
    t_awake_traffic;
    t_entry;
    t_exit;
    t_pulse;
    tick(2);
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run;
  end
endmodule